// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Sequential Read

This block is the slave end of a two-wire serial memory holding 128 bytes. It watches the clock and data lines of the bus, which arrive asynchronously and are oversampled by the system clock. It pulls the data line low through an output enable, so the pad is open-drain. A master can point the internal address pointer at a byte by writing one word-address byte. It can then read from that byte, or read from wherever the pointer was left by the last transfer. After the first byte the master can keep the read going for as long as it acknowledges. The pointer moves through all 128 locations and wraps from the top address back to zero.

The memory contents are loaded through a parallel backdoor port, which is used for test only. Data writes beyond the word address, write timing and protection are not handled.

Top module: `tws_seqread_slave`

## Requirements
- R1: After reset the slave does not drive the data line, and the address pointer is 0. A current-address read as the first transfer returns the byte at address 0.
- R2: A falling data line while the clock is high is a START, and a rising data line while the clock is high is a STOP. Either one aborts the current byte handling, and after a STOP the data line is released.
- R3: The first byte after a START carries a 7-bit device address (parameter `DEV_ADDR`) in bits 7..1 and the direction in bit 0, where 1 means read. The slave pulls the ninth bit low only when the address matches. On a mismatch it drives nothing until the next START, so a further byte clocked by the master reads as 0xFF.
- R4: After a matched write-direction address, the next byte is taken as the word address. Its bits 6..0 load the pointer, and it is acknowledged. A repeated START with a read address then returns the byte at that word address.
- R5: Data bytes are sent most significant bit first. The slave changes its drive of the data line only while the clock is low.
- R6: While the master acknowledges each byte, the slave sends the bytes at consecutive addresses n, n+1, n+2 with no new addressing.
- R7: After the byte at address 127 the next byte sent comes from address 0.
- R8: When the master leaves the acknowledge bit high, the slave stops sending and drives nothing further until a START. Bytes clocked after that point read as 0xFF.
- R9: The pointer advances once for every byte sent, whether or not that byte was acknowledged. A later current-address read starts at the byte after the last one sent.
- R10: The slave releases the data line during the master's acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| bd_we | input | 1 | Backdoor write strobe for loading the memory |
| bd_addr | input | 7 | Backdoor write address |
| bd_data | input | 8 | Backdoor write data |

## Verification
A wrong pointer shows up as a wrong byte on the bus. It appears in the first byte of the next read if the word address was loaded badly. It appears in the byte that follows the fault if the increment or wrap is broken, which is why reads start just below the top address. A phase machine left in the wrong state shows up within one byte time, either as a missing or unwanted acknowledge or as a line that is still pulled low after a NACK or an address mismatch. A drive change that comes too early shows up in the same clock-low window as a data-line edge while the clock is high.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;

    typedef logic [ADDR_W-1:0] ptr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_ACKDEV,
        ST_WADR,
        ST_ACKWADR,
        ST_TX,
        ST_MACK,
        ST_HOLD
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic addr_hit(byte_t rx, logic [6:0] dev);
        return rx[7:1] == dev;
    endfunction

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync
    import tws_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_pipe[STAGES-1];
        ev.sda      = sda_pipe[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_prev;
        ev.scl_fall = ~ev.scl & scl_prev;
        ev.start    = ev.scl & scl_prev & sda_prev & ~ev.sda;
        ev.stop     = ev.scl & scl_prev & ~sda_prev & ev.sda;
    end
endmodule

// File: rtl/tws_byte_store.sv
module tws_byte_store
    import tws_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  ptr_t  waddr,
    input  byte_t wdata,
    input  ptr_t  raddr,
    output byte_t rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/tws_seqread_slave.sv
module tws_seqread_slave
    import tws_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       bd_we,
    input  logic [6:0] bd_addr,
    input  logic [7:0] bd_data
);
    localparam logic [3:0] BITS = 4'(DATA_W);

    line_ev_t   ev;
    phase_e     phase;
    logic [3:0] cnt;
    byte_t      sh;
    ptr_t       ptr;
    byte_t      rd_data;
    logic       drv_low;
    logic       rw;
    logic       m_ack;

    tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    tws_byte_store u_store (
        .clk   (clk),
        .we    (bd_we),
        .waddr (bd_addr),
        .wdata (bd_data),
        .raddr (ptr),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            ptr     <= '0;
            drv_low <= 1'b0;
            rw      <= 1'b0;
            m_ack   <= 1'b0;
        end else if (ev.start) begin
            phase   <= ST_DEVADR;
            cnt     <= '0;
            drv_low <= 1'b0;
        end else if (ev.stop) begin
            phase   <= ST_IDLE;
            drv_low <= 1'b0;
        end else begin
            unique case (phase)
                ST_DEVADR, ST_WADR: begin
                    if (ev.scl_rise && cnt < BITS) begin
                        sh  <= {sh[DATA_W-2:0], ev.sda};
                        cnt <= cnt + 4'd1;
                    end else if (ev.scl_fall && cnt == BITS) begin
                        if (phase == ST_DEVADR) begin
                            if (addr_hit(sh, DEV_ADDR)) begin
                                drv_low <= 1'b1;
                                rw      <= sh[0];
                                phase   <= ST_ACKDEV;
                            end else begin
                                phase <= ST_HOLD;
                            end
                        end else begin
                            ptr     <= sh[ADDR_W-1:0];
                            drv_low <= 1'b1;
                            phase   <= ST_ACKWADR;
                        end
                    end
                end
                ST_ACKDEV: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            sh      <= rd_data;
                            drv_low <= ~rd_data[DATA_W-1];
                            phase   <= ST_TX;
                        end else begin
                            drv_low <= 1'b0;
                            phase   <= ST_WADR;
                        end
                    end
                end
                ST_ACKWADR: begin
                    if (ev.scl_fall) begin
                        drv_low <= 1'b0;
                        phase   <= ST_HOLD;
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (cnt == BITS - 4'd1) begin
                            drv_low <= 1'b0;
                            ptr     <= ptr + 1'b1;
                            phase   <= ST_MACK;
                        end else begin
                            sh      <= {sh[DATA_W-2:0], 1'b0};
                            drv_low <= ~sh[DATA_W-2];
                            cnt     <= cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        m_ack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (m_ack) begin
                            cnt     <= '0;
                            sh      <= rd_data;
                            drv_low <= ~rd_data[DATA_W-1];
                            phase   <= ST_TX;
                        end else begin
                            phase <= ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = drv_low;

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(drv_low) |-> !$past(ev.scl)); // R5

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_MACK && $past(phase) == ST_TX) |-> ptr == ptr_t'($past(ptr) + 1'b1)); // R9

    AST_MACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_MACK) |-> !sda_oe); // R10

    AST_START_RESTART: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> phase == ST_DEVADR); // R2

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (phase == ST_IDLE && !sda_oe)); // R2

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_HOLD && $past(phase) == ST_HOLD) |-> !sda_oe); // R8
endmodule

// File: tb/tws_seqread_slave_tb.sv
`timescale 1ns/1ps
module tws_seqread_slave_tb;
    localparam logic [6:0] DEV = 7'h50;
    localparam int Q = 80;
    localparam int NVEC = 5;
    // {start address, byte count}
    localparam logic [14:0] VEC [NVEC] = '{
        {7'd10,  8'd1},
        {7'd126, 8'd4},
        {7'd0,   8'd3},
        {7'd127, 8'd2},
        {7'd60,  8'd5}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       bd_we = 1'b0;
    logic [6:0] bd_addr = '0;
    logic [7:0] bd_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    int bad_edges = 0;
    logic prev_oe = 1'b0;
    logic [6:0] exp_ptr = '0;
    logic done = 1'b0;

    always #5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    tws_seqread_slave #(.DEV_ADDR(DEV)) u_dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .bd_we(bd_we), .bd_addr(bd_addr), .bd_data(bd_data)
    );

    // R5: the slave's drive may change only while the clock line is low
    always @(posedge clk) begin
        if (!rst && scl && sda_oe !== prev_oe) bad_edges++;
        prev_oe <= sda_oe;
    end

    function automatic logic [7:0] mval(logic [6:0] a);
        return 8'(a * 8'd29 + 8'h3C);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; #Q;
        scl = 1'b1;   #Q;
        m_sda = 1'b0; #Q;
        scl = 1'b0;   #Q;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; #Q;
        scl = 1'b1;   #Q;
        m_sda = 1'b1; #Q;
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack_low);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; #Q;
            scl = 1'b1;   #(2*Q);
            scl = 1'b0;   #Q;
        end
        m_sda = 1'b1; #Q;
        scl = 1'b1;   #Q;
        ack_low = ~sda_line; #Q;
        scl = 1'b0;   #Q;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; #Q;
            scl = 1'b1;   #Q;
            b[i] = sda_line; #Q;
            scl = 1'b0;   #Q;
        end
        m_sda = give_ack ? 1'b0 : 1'b1; #Q;
        scl = 1'b1; #Q;
        chk("R10 slave released in master ack bit", 32'(sda_oe), 32'd0);
        #Q;
        scl = 1'b0; #Q;
        m_sda = 1'b1;
    endtask

    task automatic read_run(input int n, input string req);
        logic [7:0] got;
        for (int k = 0; k < n; k++) begin
            rbyte(k < n - 1, got);
            chk(req, 32'(got), 32'(mval(exp_ptr)));
            exp_ptr = exp_ptr + 7'd1;
        end
    endtask

    task automatic rand_read(input logic [6:0] a, input int n);
        logic ack;
        bus_start();
        wbyte({DEV, 1'b0}, ack);
        chk("R3 write address acked", 32'(ack), 32'd1);
        wbyte({1'b0, a}, ack);
        chk("R4 word address acked", 32'(ack), 32'd1);
        exp_ptr = a;
        bus_start();
        wbyte({DEV, 1'b1}, ack);
        chk("R4 read address acked", 32'(ack), 32'd1);
        read_run(n, "R6 R7 R4 sequential data");
        bus_stop();
    endtask

    task automatic cur_read(input int n, input string req);
        logic ack;
        bus_start();
        wbyte({DEV, 1'b1}, ack);
        chk("R3 read address acked", 32'(ack), 32'd1);
        read_run(n, req);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic ack;
        logic [7:0] got;
        #3;
        for (int a = 0; a < 128; a++) begin
            bd_we = 1'b1; bd_addr = 7'(a); bd_data = mval(7'(a));
            #10;
        end
        bd_we = 1'b0;
        #40;
        rst = 1'b0;
        #40;
        chk("R1 line released after reset", 32'(sda_oe), 32'd0);

        // R1: pointer starts at 0
        exp_ptr = '0;
        cur_read(1, "R1 first current-address read");
        bus_stop();
        chk("R2 released after STOP", 32'(sda_oe), 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            rand_read(VEC[v][14:8], int'(VEC[v][7:0]));
        end

        // R9: last NACKed byte still advanced the pointer
        cur_read(2, "R9 current read continues after NACKed byte");
        bus_stop();

        // R3: mismatched device address
        bus_start();
        wbyte({DEV ^ 7'h01, 1'b1}, ack);
        chk("R3 mismatch not acked", 32'(ack), 32'd0);
        rbyte(1'b0, got);
        chk("R3 no drive after mismatch", 32'(got), 32'hFF);
        bus_stop();

        // R8: NACK ends the stream, further clocks read high
        cur_read(1, "R6 single byte before NACK");
        rbyte(1'b0, got);
        chk("R8 no data after NACK", 32'(got), 32'hFF);
        bus_stop();
        chk("R2 released after STOP following NACK", 32'(sda_oe), 32'd0);
        cur_read(1, "R9 pointer after NACK ending");
        bus_stop();

        // R7: wrap straight from 127 to 0 via current-address read
        rand_read(7'd125, 1);
        cur_read(3, "R7 wrap in current-address stream");
        bus_stop();

        #(4*Q);
        chk("R5 drive changed only with clock low", 32'(bad_edges), 32'd0);
        finish_run();
    end
endmodule